// File: doc/BRIEF.md
# Microframe Frame Index Counter

This block holds the 14-bit frame index of a high-speed host controller. While the controller is running, the index steps by one on each microframe tick. A timer outside the block raises this tick once every 125 microseconds. The three low bits count the eight microframes inside a frame. The bits above them select the entry of the periodic frame list. How many bits that entry selector uses depends on a 2-bit list-size code. Each time the selected span of the index wraps to zero, the block raises a one-cycle rollover pulse. That pulse is meant to set the controller's list-rollover status flag.

Software reads the index through a 32-bit data port at any time. A write is taken only when it covers all four byte lanes, the controller reports halted, and the run control is clear. Any other write is dropped. The upper part of the index is also given out as the frame number for start-of-frame generation, so a write moves that number as well.

Top module: `frame_index_ctr`

## Requirements
- R1: After reset, rd_data_o, list_idx_o and frame_num_o are 0 and rollover_o is 0.
- R2: While run_i=1 and halted_i=0, each cycle with utick_i=1 increases the 14-bit index by one, visible on rd_data_o after that clock edge.
- R3: The index holds when utick_i=0, when run_i=0, or when halted_i=1, unless a write is accepted.
- R4: list_idx_o carries index bits N down to 3, zero-extended to 10 bits. The list_size_i code sets N: code 0 gives N=12 (1024 entries), 1 gives N=11 (512), 2 gives N=10 (256), and the reserved code 3 behaves as code 0.
- R5: rollover_o is high for exactly the one cycle after an advance that takes index bits N down to 0 from all ones to zero. An advance that does not do this leaves it low.
- R6: A write (wr_en_i=1) with wr_be_i=4'b1111, halted_i=1 and run_i=0 loads wr_data_i[13:0] into the index at that clock edge.
- R7: A write while run_i=1, or while halted_i=0, leaves the index unchanged.
- R8: A write with any byte enable bit clear leaves the index unchanged.
- R9: rd_data_o[31:14] always reads 0, even after a write with those bits set.
- R10: frame_num_o carries index bits 13 down to 3 and follows both writes and advances.
- R11: The full 14-bit index wraps from 16383 to 0 on an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| utick_i | input | 1 | One-cycle microframe tick |
| run_i | input | 1 | Run control bit |
| halted_i | input | 1 | Controller halted indication |
| list_size_i | input | 2 | Frame list size code |
| wr_en_i | input | 1 | Write strobe for the index |
| wr_be_i | input | 4 | Byte enables of the write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Index read value |
| list_idx_o | output | 10 | Periodic list entry index |
| frame_num_o | output | 11 | Frame number for start-of-frame |
| rollover_o | output | 1 | One-cycle list rollover pulse |

## Verification
The bench uses the default parameters: a 32-bit data port, a 14-bit index, three microframe bits and at most 1024 list entries. The index can be loaded while halted, so the bench seeds values just below each wrap point. This lets it reach the rollover of every list size, and the full 14-bit wrap, in a few ticks instead of thousands. It runs the same write image under all four size codes, which shows the entry index shrinking with the code and code 3 matching code 0.

// File: rtl/fidx_pkg.sv
package fidx_pkg;
  typedef enum logic [1:0] {
    LS_1024 = 2'd0,
    LS_512  = 2'd1,
    LS_256  = 2'd2,
    LS_RSVD = 2'd3
  } list_size_e;
endpackage

// File: rtl/fidx_size_dec.sv
module fidx_size_dec
  import fidx_pkg::*;
#(
  parameter int IDX_W       = 14,
  parameter int UF_W        = 3,
  parameter int MAX_LOG_ENT = 10
) (
  input  logic [1:0]             size_i,
  output logic [IDX_W-1:0]       wrap_mask_o,
  output logic [MAX_LOG_ENT-1:0] ent_mask_o
);
  int unsigned log_ent;

  always_comb begin
    unique case (list_size_e'(size_i))
      LS_512:  log_ent = MAX_LOG_ENT - 1;
      LS_256:  log_ent = MAX_LOG_ENT - 2;
      default: log_ent = MAX_LOG_ENT;  // reserved code acts as largest list
    endcase
  end

  always_comb begin
    for (int b = 0; b < IDX_W; b++)
      wrap_mask_o[b] = (unsigned'(b) < (log_ent + UF_W));
    for (int b = 0; b < MAX_LOG_ENT; b++)
      ent_mask_o[b] = (unsigned'(b) < log_ent);
  end
endmodule

// File: rtl/fidx_wr_qual.sv
module fidx_wr_qual #(
  parameter int BE_W = 4
) (
  input  logic            wr_en_i,
  input  logic [BE_W-1:0] wr_be_i,
  input  logic            run_i,
  input  logic            halted_i,
  input  logic            utick_i,
  output logic            load_o,
  output logic            adv_o
);
  logic full_word;

  assign full_word = &wr_be_i;
  // loads only when stopped and halted; advance only when running
  assign load_o    = wr_en_i && full_word && halted_i && !run_i;
  assign adv_o     = utick_i && run_i && !halted_i;
endmodule

// File: rtl/fidx_counter.sv
module fidx_counter #(
  parameter int IDX_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic [IDX_W-1:0] wrap_mask_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             rollover_o
);
  logic [IDX_W-1:0] idx_q;
  logic             roll_q;
  logic             at_wrap;

  assign at_wrap = (idx_q & wrap_mask_i) == wrap_mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      roll_q <= 1'b0;
    end else begin
      if (load_i)     idx_q <= load_val_i;
      else if (adv_i) idx_q <= idx_q + 1'b1;
      roll_q <= adv_i && !load_i && at_wrap;
    end
  end

  assign idx_o      = idx_q;
  assign rollover_o = roll_q;
endmodule

// File: rtl/frame_index_ctr.sv
module frame_index_ctr #(
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 14,
  parameter int UF_W        = 3,
  parameter int MAX_LOG_ENT = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   utick_i,
  input  logic                   run_i,
  input  logic                   halted_i,
  input  logic [1:0]             list_size_i,
  input  logic                   wr_en_i,
  input  logic [DATA_W/8-1:0]    wr_be_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic [MAX_LOG_ENT-1:0] list_idx_o,
  output logic [IDX_W-UF_W-1:0]  frame_num_o,
  output logic                   rollover_o
);
  localparam int BE_W  = DATA_W / 8;
  localparam int ENT_W = MAX_LOG_ENT;

  logic             load, adv;
  logic [IDX_W-1:0] idx, wrap_mask;
  logic [ENT_W-1:0] ent_mask;

  fidx_wr_qual #(.BE_W(BE_W)) u_qual (
    .wr_en_i (wr_en_i),
    .wr_be_i (wr_be_i),
    .run_i   (run_i),
    .halted_i(halted_i),
    .utick_i (utick_i),
    .load_o  (load),
    .adv_o   (adv)
  );

  fidx_size_dec #(
    .IDX_W(IDX_W), .UF_W(UF_W), .MAX_LOG_ENT(MAX_LOG_ENT)
  ) u_dec (
    .size_i     (list_size_i),
    .wrap_mask_o(wrap_mask),
    .ent_mask_o (ent_mask)
  );

  fidx_counter #(.IDX_W(IDX_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adv_i      (adv),
    .load_i     (load),
    .load_val_i (wr_data_i[IDX_W-1:0]),
    .wrap_mask_i(wrap_mask),
    .idx_o      (idx),
    .rollover_o (rollover_o)
  );

  assign rd_data_o   = DATA_W'(idx);
  assign list_idx_o  = idx[UF_W +: ENT_W] & ent_mask;
  assign frame_num_o = idx[IDX_W-1:UF_W];
endmodule

// File: rtl/frame_index_ctr_chk.sv
module frame_index_ctr_chk #(
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 14,
  parameter int UF_W        = 3,
  parameter int MAX_LOG_ENT = 10
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   utick_i,
  input logic                   run_i,
  input logic                   halted_i,
  input logic [1:0]             list_size_i,
  input logic                   wr_en_i,
  input logic [DATA_W/8-1:0]    wr_be_i,
  input logic [DATA_W-1:0]      wr_data_i,
  input logic [DATA_W-1:0]      rd_data_o,
  input logic [MAX_LOG_ENT-1:0] list_idx_o,
  input logic [IDX_W-UF_W-1:0]  frame_num_o,
  input logic                   rollover_o
);
  localparam int MIN_WRAP = UF_W + MAX_LOG_ENT - 2;

  logic acc_wr, acc_tick;
  assign acc_wr   = wr_en_i && (&wr_be_i) && halted_i && !run_i;
  assign acc_tick = utick_i && run_i && !halted_i;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_tick |=> rd_data_o[IDX_W-1:0] == $past(rd_data_o[IDX_W-1:0]) + 1'b1);

  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_tick && !acc_wr) |=> $stable(rd_data_o));

  a_r4_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (list_size_i == 2'd2) |-> (list_idx_o[MAX_LOG_ENT-1 -: 2] == 2'b00));

  a_r5_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollover_o |=> !rollover_o);

  a_r5_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollover_o |-> (rd_data_o[MIN_WRAP-1:0] == '0));

  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr |=> rd_data_o[IDX_W-1:0] == $past(wr_data_i[IDX_W-1:0]));

  a_r9_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_wr && (wr_data_i[DATA_W-1:IDX_W] != '0)) |=> (rd_data_o[DATA_W-1:IDX_W] == '0));

  a_r10_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_wr |=> frame_num_o == $past(wr_data_i[IDX_W-1:UF_W]));
endmodule

bind frame_index_ctr frame_index_ctr_chk #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .UF_W(UF_W), .MAX_LOG_ENT(MAX_LOG_ENT)
) u_chk (.*);

// File: tb/frame_index_ctr_tb.sv
module frame_index_ctr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        utick = 1'b0, run = 1'b0, halted = 1'b1;
  logic [1:0]  lsize = 2'd0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = 4'h0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [9:0]  list_idx;
  logic [10:0] frame_num;
  logic        roll;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  frame_index_ctr u_dut (
    .clk_i(clk), .rst_ni(rst_n), .utick_i(utick), .run_i(run),
    .halted_i(halted), .list_size_i(lsize), .wr_en_i(wr_en),
    .wr_be_i(wr_be), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .list_idx_o(list_idx), .frame_num_o(frame_num), .rollover_o(roll)
  );

  typedef struct packed {
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp_rd;
    logic [9:0]  exp_idx;
    logic [10:0] exp_frm;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 32'h0000_1FF8, 32'h0000_1FF8, 10'h3FF, 11'h3FF},
    '{2'd1, 32'h0000_1FF8, 32'h0000_1FF8, 10'h1FF, 11'h3FF},
    '{2'd2, 32'h0000_1FF8, 32'h0000_1FF8, 10'h0FF, 11'h3FF},
    '{2'd3, 32'h0000_1FF8, 32'h0000_1FF8, 10'h3FF, 11'h3FF},
    '{2'd0, 32'hFFFF_FFFF, 32'h0000_3FFF, 10'h3FF, 11'h7FF},
    '{2'd2, 32'h0000_2A5D, 32'h0000_2A5D, 10'h04B, 11'h54B},
    '{2'd1, 32'h1234_5678, 32'h0000_1678, 10'h0CF, 11'h2CF},
    '{2'd0, 32'h0000_0000, 32'h0000_0000, 10'h000, 11'h000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    utick = 1'b1;
    @(negedge clk);
    utick = 1'b0;
  endtask

  task automatic set_mode(input logic r, input logic h);
    @(negedge clk);
    run = r; halted = h;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd", rd_data, 32'h0);
    check("R1 idx", {22'h0, list_idx}, 32'h0);
    check("R1 frame", {21'h0, frame_num}, 32'h0);
    check("R1 roll", {31'h0, roll}, 32'h0);
    rst_n = 1'b1;

    // R6 R4 R10 R9 table
    set_mode(1'b0, 1'b1);
    foreach (VECS[i]) begin
      lsize = VECS[i].size;
      do_write(VECS[i].wdata, 4'hF);
      check("R6 R9 rd", rd_data, VECS[i].exp_rd);
      check("R4 list idx", {22'h0, list_idx}, {22'h0, VECS[i].exp_idx});
      check("R10 frame", {21'h0, frame_num}, {21'h0, VECS[i].exp_frm});
    end

    // R2 advance
    lsize = 2'd0;
    set_mode(1'b1, 1'b0);
    for (int k = 0; k < 5; k++) do_tick();
    check("R2 advance", rd_data, 32'd5);
    check("R10 frame after advance", {21'h0, frame_num}, 32'd0);

    // R3 hold
    repeat (6) @(negedge clk);
    check("R3 no tick", rd_data, 32'd5);
    set_mode(1'b0, 1'b0);
    do_tick();
    check("R3 run clear", rd_data, 32'd5);
    set_mode(1'b1, 1'b1);
    do_tick();
    check("R3 halted", rd_data, 32'd5);

    // R7 write rejected
    do_write(32'h100, 4'hF);
    check("R7 run and halted", rd_data, 32'd5);
    set_mode(1'b1, 1'b0);
    do_write(32'h100, 4'hF);
    check("R7 running", rd_data, 32'd6 - 32'd1);
    set_mode(1'b0, 1'b0);
    do_write(32'h100, 4'hF);
    check("R7 not halted", rd_data, 32'd5);

    // R8 partial writes
    set_mode(1'b0, 1'b1);
    do_write(32'h100, 4'b0111);
    check("R8 be 0111", rd_data, 32'd5);
    do_write(32'h100, 4'b1110);
    check("R8 be 1110", rd_data, 32'd5);

    // R5 rollover, 256 entries: wrap of bits 10:0
    lsize = 2'd2;
    do_write(32'h7FE, 4'hF);
    set_mode(1'b1, 1'b0);
    do_tick();
    check("R5 no pulse before wrap", {31'h0, roll}, 32'h0);
    do_tick();
    check("R5 rd at wrap", rd_data, 32'h800);
    check("R5 pulse 256", {31'h0, roll}, 32'h1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'h0, roll}, 32'h0);

    // R5 same crossing with 1024 entries gives no pulse
    set_mode(1'b0, 1'b1);
    lsize = 2'd0;
    do_write(32'h7FF, 4'hF);
    set_mode(1'b1, 1'b0);
    do_tick();
    check("R5 no pulse 1024", {31'h0, roll}, 32'h0);
    check("R2 carry", rd_data, 32'h800);

    // R5 512 entries: wrap of bits 11:0
    set_mode(1'b0, 1'b1);
    lsize = 2'd1;
    do_write(32'hFFF, 4'hF);
    set_mode(1'b1, 1'b0);
    do_tick();
    check("R5 pulse 512", {31'h0, roll}, 32'h1);
    check("R5 rd 512", rd_data, 32'h1000);

    // R5 reserved code behaves as 1024
    set_mode(1'b0, 1'b1);
    lsize = 2'd3;
    do_write(32'hFFF, 4'hF);
    set_mode(1'b1, 1'b0);
    do_tick();
    check("R5 R4 reserved no pulse", {31'h0, roll}, 32'h0);

    // R11 full wrap
    set_mode(1'b0, 1'b1);
    lsize = 2'd0;
    do_write(32'h3FFF, 4'hF);
    set_mode(1'b1, 1'b0);
    do_tick();
    check("R11 full wrap", rd_data, 32'h0);
    check("R11 R5 pulse", {31'h0, roll}, 32'h1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule